// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block takes 16-bit commands from a register write port and carries them out against a bank of per-slot state held inside the block. Each slot has a 2-bit slot state, a 2-bit power indicator and a 2-bit attention indicator. The block also keeps the current bus speed/mode code for the segment. Bits 7:0 of a command word hold the command code and bits 15:8 hold the target slot number.

A command is accepted only while the controller is idle. After acceptance the busy flag stays high for a fixed number of cycles. When busy drops, three things happen in the same cycle: the command's effect is applied, the error field is written, and a command-detected flag is set. That flag is cleared by writing 1 to it. It drives an interrupt line unless one of two mask bits is set.

Software uses the block by polling busy or by waiting for the interrupt. It then reads the error field to learn whether the command took effect. Power sequencing and bus clock switching lie outside the block. The slot state and speed code are only reported on output ports.

Top module: `hpc_cmd_exec`

## Requirements
- R1: After reset the block is in this state: busy is 0 and the error field is 0. Every slot state is 11 (disabled). Every power and attention indicator is 11 (off). The bus mode is 0. Both mask bits are 1 and the detected flag is 0.
- R2: A command write while idle is accepted at that clock edge. status[0] (busy) is high for exactly BUSY_CYCLES cycles after it. The effect and the error field appear in the cycle busy falls.
- R3: A command write while busy is high is ignored. It has no effect on slots, mode or status.
- R4: Codes 00h–3Fh are slot operations with three fields. Bits 1:0 are the slot state (01 power-only, 10 enabled, 11 disabled). Bits 3:2 are the power indicator and bits 5:4 are the attention indicator (01 on, 10 blink, 11 off). A field of 00 leaves that item unchanged.
- R5: If a slot operation requests power-only or enabled for a slot whose latch_open bit is 1, it completes with error 001 (status[1], switch open). None of that slot's fields change. Disabling such a slot is allowed.
- R6: A slot operation whose slot number is NUM_SLOTS or above completes with error 010 (status[2], invalid command) and changes nothing.
- R7: Code 48h sets every slot with a closed latch to power-only (01). Code 49h sets every such slot to enabled (10). If any latch is open, those slots keep their state and the error is 001. Indicators are untouched.
- R8: Codes 40h–44h set the bus mode to code[2:0]. Codes 45h–47h are reserved and give error 010 with the mode unchanged.
- R9: Codes 50h–5Dh set the bus mode to code[3:0]. When pi2 is 0 and code[3:0] is above 4, the command gives error 100 (status[3], invalid speed/mode) and the mode is unchanged. Codes 5Eh and 5Fh give error 010.
- R10: Codes 4Ah–4Fh, 60h–BFh and C0h–FFh give error 010 and change nothing.
- R11: The error field changes only in the cycle busy falls, and at most one of its bits is set.
- R12: Completion sets ctl_rdata[16]. A control write loads bit 0 (global mask) and bit 2 (command mask) from ctl_wdata. Writing 1 to bit 16 clears the detected flag.
- R13: irq is high exactly when the detected flag is 1 and both mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command word: slot in 15:8, code in 7:0 |
| pi2 | input | 1 | 1 selects the wider speed/mode interface revision |
| latch_open | input | NUM_SLOTS | Per-slot latch sensor, 1 = open |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data: mask bits 0 and 2, clear bit 16 |
| status | output | 4 | Bit 0 busy, bits 3:1 error |
| ctl_rdata | output | 32 | Control register: masks in bits 0 and 2, detected in bit 16 |
| irq | output | 1 | Command-complete interrupt |
| slot_state | output | 2*NUM_SLOTS | Slot state, slot i in bits 2i+1:2i |
| pwr_ind | output | 2*NUM_SLOTS | Power indicator per slot |
| attn_ind | output | 2*NUM_SLOTS | Attention indicator per slot |
| bus_mode | output | 4 | Current bus speed/mode code |

## Verification
The hardest case to reach from the ports is a second command write that lands inside the busy window, including the cycle in which busy falls. The stimulus issues a command and writes a conflicting one two cycles later. It then checks that only the first command's indicator change appears and that busy stays low afterwards. A second hard area is the set of mixed all-slot cases, where only some latches are open and the partial update and the error must appear together. The stimulus drives one open latch together with code 49h for this. It also switches pi2 between speed commands to reach the invalid-speed path.

// File: rtl/hpc_cmd_pkg.sv
package hpc_cmd_pkg;

    localparam logic [2:0] ERR_NONE = 3'b000;
    localparam logic [2:0] ERR_SW   = 3'b001;
    localparam logic [2:0] ERR_CMD  = 3'b010;
    localparam logic [2:0] ERR_SPD  = 3'b100;

    localparam logic [1:0] FLD_KEEP = 2'b00;
    localparam logic [1:0] ST_PWR   = 2'b01;
    localparam logic [1:0] ST_EN    = 2'b10;
    localparam logic [1:0] ST_DIS   = 2'b11;

    localparam logic [7:0] CODE_ALL_PWR = 8'h48;
    localparam logic [7:0] CODE_ALL_EN  = 8'h49;

    typedef struct packed {
        logic       is_slot;
        logic       is_all;
        logic       all_en;
        logic       is_speed;
        logic [3:0] mode;
        logic [2:0] err;
    } dec_t;

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [7:0]           code,
    input  logic [7:0]           slot,
    input  logic                 pi2,
    input  logic [NUM_SLOTS-1:0] latch_open,
    output dec_t                 dec
);
    localparam logic [7:0] NS8 = 8'(NUM_SLOTS);

    logic latch_sel;

    always_comb begin
        latch_sel = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot == 8'(i)) latch_sel = latch_open[i];
        end
    end

    always_comb begin
        dec = '0;
        if (code[7:6] == 2'b00) begin
            if (slot >= NS8) begin
                dec.err = ERR_CMD;
            end else if ((code[1:0] == ST_PWR || code[1:0] == ST_EN) && latch_sel) begin
                dec.err = ERR_SW;
            end else begin
                dec.is_slot = 1'b1;
            end
        end else if (code[7:3] == 5'b01000) begin
            if (code[2:0] <= 3'd4) begin
                dec.is_speed = 1'b1;
                dec.mode     = {1'b0, code[2:0]};
            end else begin
                dec.err = ERR_CMD;
            end
        end else if (code == CODE_ALL_PWR || code == CODE_ALL_EN) begin
            dec.is_all = 1'b1;
            dec.all_en = code[0];
            if (|latch_open) dec.err = ERR_SW;
        end else if (code[7:4] == 4'h5) begin
            if (code[3:0] >= 4'hE) begin
                dec.err = ERR_CMD;
            end else if (!pi2 && code[3:0] > 4'd4) begin
                dec.err = ERR_SPD;
            end else begin
                dec.is_speed = 1'b1;
                dec.mode     = code[3:0];
            end
        end else begin
            dec.err = ERR_CMD;
        end
    end

endmodule

// File: rtl/hpc_slot_update.sv
module hpc_slot_update
    import hpc_cmd_pkg::*;
(
    input  logic [1:0] st_q,
    input  logic [1:0] pw_q,
    input  logic [1:0] at_q,
    input  logic       apply_slot,
    input  logic [1:0] st_f,
    input  logic [1:0] pw_f,
    input  logic [1:0] at_f,
    input  logic       apply_all,
    input  logic       all_en,
    output logic [1:0] st_d,
    output logic [1:0] pw_d,
    output logic [1:0] at_d
);
    always_comb begin
        st_d = st_q;
        pw_d = pw_q;
        at_d = at_q;
        if (apply_all) begin
            st_d = all_en ? ST_EN : ST_PWR;
        end else if (apply_slot) begin
            if (st_f != FLD_KEEP) st_d = st_f;
            if (pw_f != FLD_KEEP) pw_d = pw_f;
            if (at_f != FLD_KEEP) at_d = at_f;
        end
    end
endmodule

// File: rtl/hpc_cmd_exec.sv
module hpc_cmd_exec
    import hpc_cmd_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int BUSY_CYCLES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  logic [15:0]            cmd_wdata,
    input  logic                   pi2,
    input  logic [NUM_SLOTS-1:0]   latch_open,
    input  logic                   ctl_wr,
    input  logic [31:0]            ctl_wdata,
    output logic [3:0]             status,
    output logic [31:0]            ctl_rdata,
    output logic                   irq,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] pwr_ind,
    output logic [2*NUM_SLOTS-1:0] attn_ind,
    output logic [3:0]             bus_mode
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam int VW    = 2 * NUM_SLOTS;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [15:0]      cmd;
        logic [2:0]       err;
        logic [3:0]       mode;
        logic [VW-1:0]    st;
        logic [VW-1:0]    pw;
        logic [VW-1:0]    at;
        logic             gmask;
        logic             cmask;
        logic             det;
    } regs_t;

    regs_t r_q, r_d;
    dec_t  dec;
    logic  done;
    logic [VW-1:0] st_nx, pw_nx, at_nx;

    assign done = r_q.busy && (r_q.cnt == '0);

    hpc_cmd_decode #(.NUM_SLOTS(NUM_SLOTS)) u_dec (
        .code       (r_q.cmd[7:0]),
        .slot       (r_q.cmd[15:8]),
        .pi2        (pi2),
        .latch_open (latch_open),
        .dec        (dec)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        hpc_slot_update u_upd (
            .st_q       (r_q.st[2*g +: 2]),
            .pw_q       (r_q.pw[2*g +: 2]),
            .at_q       (r_q.at[2*g +: 2]),
            .apply_slot (done && dec.is_slot && (r_q.cmd[15:8] == 8'(g))),
            .st_f       (r_q.cmd[1:0]),
            .pw_f       (r_q.cmd[3:2]),
            .at_f       (r_q.cmd[5:4]),
            .apply_all  (done && dec.is_all && !latch_open[g]),
            .all_en     (dec.all_en),
            .st_d       (st_nx[2*g +: 2]),
            .pw_d       (pw_nx[2*g +: 2]),
            .at_d       (at_nx[2*g +: 2])
        );
    end

    always_comb begin
        r_d    = r_q;
        r_d.st = st_nx;
        r_d.pw = pw_nx;
        r_d.at = at_nx;
        if (ctl_wr) begin
            r_d.gmask = ctl_wdata[0];
            r_d.cmask = ctl_wdata[2];
            if (ctl_wdata[16]) r_d.det = 1'b0;
        end
        if (!r_q.busy) begin
            if (cmd_wr) begin
                r_d.busy = 1'b1;
                r_d.cnt  = CNT_LOAD;
                r_d.cmd  = cmd_wdata;
            end
        end else if (done) begin
            r_d.busy = 1'b0;
            r_d.err  = dec.err;
            r_d.det  = 1'b1;
            if (dec.is_speed) r_d.mode = dec.mode;
        end else begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= '1;
            r_q.pw    <= '1;
            r_q.at    <= '1;
            r_q.gmask <= 1'b1;
            r_q.cmask <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign status     = {r_q.err, r_q.busy};
    assign ctl_rdata  = {15'b0, r_q.det, 13'b0, r_q.cmask, 1'b0, r_q.gmask};
    assign irq        = r_q.det && !r_q.gmask && !r_q.cmask;
    assign slot_state = r_q.st;
    assign pwr_ind    = r_q.pw;
    assign attn_ind   = r_q.at;
    assign bus_mode   = r_q.mode;

endmodule

// File: rtl/hpc_cmd_exec_chk.sv
module hpc_cmd_exec_chk #(
    parameter int NUM_SLOTS   = 4,
    parameter int BUSY_CYCLES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_wr,
    input logic [3:0]             status,
    input logic [31:0]            ctl_rdata,
    input logic                   irq,
    input logic [2*NUM_SLOTS-1:0] slot_state,
    input logic [2*NUM_SLOTS-1:0] pwr_ind,
    input logic [2*NUM_SLOTS-1:0] attn_ind,
    input logic [3:0]             bus_mode
);
    int run_len;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_len <= 0;
        else if (status[0]) run_len <= run_len + 1;
        else                run_len <= 0;
    end

    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> (run_len == BUSY_CYCLES));

    assert_start_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[0]) |-> $past(cmd_wr));

    assert_state_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(status[0]) |-> ($stable(slot_state) && $stable(pwr_ind)
                               && $stable(attn_ind) && $stable(bus_mode)));

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(status[0]) |-> $stable(status[3:1]));

    assert_err_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[3:1]));

    assert_detect_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> ctl_rdata[16]);

    assert_irq_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ctl_rdata[16] && !ctl_rdata[0] && !ctl_rdata[2]));

endmodule

bind hpc_cmd_exec hpc_cmd_exec_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .status     (status),
    .ctl_rdata  (ctl_rdata),
    .irq        (irq),
    .slot_state (slot_state),
    .pwr_ind    (pwr_ind),
    .attn_ind   (attn_ind),
    .bus_mode   (bus_mode)
);

// File: tb/hpc_cmd_exec_bench.sv
module hpc_cmd_exec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 4;
    localparam int BUSY = 8;
    localparam int NVEC = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [15:0]   cmd_wdata = '0;
    logic          pi2 = 1'b1;
    logic [NS-1:0] latch_open = '0;
    logic          ctl_wr = 1'b0;
    logic [31:0]   ctl_wdata = '0;
    logic [3:0]    status;
    logic [31:0]   ctl_rdata;
    logic          irq;
    logic [2*NS-1:0] slot_state, pwr_ind, attn_ind;
    logic [3:0]    bus_mode;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpc_cmd_exec #(.NUM_SLOTS(NS), .BUSY_CYCLES(BUSY)) u_hpc_cmd_exec (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .pi2(pi2), .latch_open(latch_open), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .status(status), .ctl_rdata(ctl_rdata), .irq(irq),
        .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
        .bus_mode(bus_mode)
    );

    // {cmd, pi2, latch, state, pwr, attn, mode, err}
    localparam logic [51:0] VEC [NVEC] = '{
        {16'h003A, 1'b1, 4'h0, 8'hFE, 8'hFE, 8'hFF, 4'h0, 3'b000}, // R4
        {16'h0215, 1'b1, 4'h0, 8'hDE, 8'hDE, 8'hDF, 4'h0, 3'b000}, // R4
        {16'h0120, 1'b1, 4'h0, 8'hDE, 8'hDE, 8'hDB, 4'h0, 3'b000}, // R4 keep fields
        {16'h0401, 1'b1, 4'h0, 8'hDE, 8'hDE, 8'hDB, 4'h0, 3'b010}, // R6
        {16'h0102, 1'b1, 4'h2, 8'hDE, 8'hDE, 8'hDB, 4'h0, 3'b001}, // R5
        {16'h0003, 1'b1, 4'h2, 8'hDF, 8'hDE, 8'hDB, 4'h0, 3'b000}, // R5 disable ok
        {16'h0043, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h3, 3'b000}, // R8
        {16'h0045, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h3, 3'b010}, // R8 reserved
        {16'h005B, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'hB, 3'b000}, // R9
        {16'h0057, 1'b0, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'hB, 3'b100}, // R9 bad speed
        {16'h0054, 1'b0, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h4, 3'b000}, // R9
        {16'h005E, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h4, 3'b010}, // R9 reserved
        {16'h0080, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h4, 3'b010}, // R10
        {16'h0000, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h4, 3'b000}, // R4 no-op
        {16'h00C3, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h4, 3'b010}, // R10
        {16'h004B, 1'b1, 4'h0, 8'hDF, 8'hDE, 8'hDB, 4'h4, 3'b010}, // R10
        {16'h0049, 1'b1, 4'h8, 8'hEA, 8'hDE, 8'hDB, 4'h4, 3'b001}, // R7
        {16'h0048, 1'b1, 4'h0, 8'h55, 8'hDE, 8'hDB, 4'h4, 3'b000}  // R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [15:0] c, input logic p, input logic [NS-1:0] l);
        @(negedge clk);
        pi2 = p; latch_open = l; cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic ctl_write(input logic [31:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 slot_state", 32'(slot_state), 32'hFF);
        chk("R1 pwr_ind", 32'(pwr_ind), 32'hFF);
        chk("R1 attn_ind", 32'(attn_ind), 32'hFF);
        chk("R1 bus_mode", 32'(bus_mode), 32'h0);
        chk("R1 ctl_rdata", ctl_rdata, 32'h0000_0005);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 busy duration
        start_cmd(16'h0000, 1'b1, '0);
        hi = 0;
        while (status[0] && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        chk("R2 busy cycles", 32'(hi), 32'(BUSY));
        chk("R12 detected set", 32'(ctl_rdata[16]), 32'h1);
        chk("R13 irq masked", 32'(irq), 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [51:0] e;
            e = VEC[v];
            start_cmd(e[51:36], e[35], e[34:31]);
            chk("R2 busy during", 32'(status[0]), 32'h1);
            repeat (BUSY) @(negedge clk);
            chk("R2 busy cleared", 32'(status[0]), 32'h0);
            chk("R11 error field", 32'(status[3:1]), 32'(e[2:0]));
            chk("R4 slot_state", 32'(slot_state), 32'(e[30:23]));
            chk("R4 pwr_ind", 32'(pwr_ind), 32'(e[22:15]));
            chk("R4 attn_ind", 32'(attn_ind), 32'(e[14:7]));
            chk("R8 bus_mode", 32'(bus_mode), 32'(e[6:3]));
        end

        // R3 write during busy is ignored
        start_cmd(16'h0011, 1'b1, '0);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 16'h0130;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (BUSY - 2) @(negedge clk);
        chk("R3 busy cleared", 32'(status[0]), 32'h0);
        chk("R3 attn first only", 32'(attn_ind), 32'hD9);
        chk("R3 state", 32'(slot_state), 32'h55);
        repeat (BUSY + 2) @(negedge clk);
        chk("R3 no second run", 32'(status[0]), 32'h0);
        chk("R3 attn unchanged", 32'(attn_ind), 32'hD9);

        // R3 write in the very cycle busy falls
        start_cmd(16'h0030, 1'b1, '0);
        repeat (BUSY - 1) @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 16'h0120;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R3 edge busy", 32'(status[0]), 32'h0);
        chk("R3 edge attn", 32'(attn_ind), 32'hDB);

        // R12/R13 masks and clear
        ctl_write(32'h0000_0000);
        chk("R12 masks cleared", ctl_rdata, 32'h0001_0000);
        chk("R13 irq raised", 32'(irq), 32'h1);
        ctl_write(32'h0000_0004);
        chk("R13 cmd mask", 32'(irq), 32'h0);
        ctl_write(32'h0000_0001);
        chk("R13 global mask", 32'(irq), 32'h0);
        ctl_write(32'h0001_0000);
        chk("R12 detected cleared", ctl_rdata, 32'h0);
        chk("R13 irq low", 32'(irq), 32'h0);
        start_cmd(16'h0000, 1'b1, '0);
        repeat (BUSY) @(negedge clk);
        chk("R13 irq on completion", 32'(irq), 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule